// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation-buffer miss in hardware. A requester hands it a 64-bit virtual address and an access type. It then reads up to three page table entries in turn through a single-outstanding request/response memory port. The first read starts from a root table base supplied with the request. The walk ends in one of two ways. It can return a physical address together with the leaf's read/write/execute bits, or it can report a fault and the level at which the walk failed.

The virtual address is sliced from bit 0 upward as follows. Bits 12:0 are the page offset (8 KiB pages). Bits 22:13 are the leaf index, bits 32:23 the middle index and bits 42:33 the root index. Bits 63:43 are ignored. Each entry is 64 bits wide:

| Bits | Meaning |
|------|---------|
| 0 | valid |
| 1 | read |
| 2 | write |
| 3 | execute |
| 4 | large-page flag, legal only at the middle level |
| 63:13 | frame number |

A middle-level entry that carries the large flag maps an 8 MiB huge page, and the walk stops there.

The block takes one walk at a time. Its results stay on the outputs from the done pulse until the next request is accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset, reqReady is 1 and both doneValid and memReqValid are 0.
- R2: The entry for a level is read at table base + index × 8. The indices are: root = vaddr[42:33], middle = vaddr[32:23], leaf = vaddr[22:13].
- R3: Reads go root, then middle, then leaf. A non-terminal entry gives the next table base as {entry[63:13], 13'b0}.
- R4: A permitted 8 KiB leaf gives donePaddr = {entry[63:13], vaddr[12:0]}, donePerm = entry[3:1] (bit 0 read, bit 1 write, bit 2 execute), doneHuge = 0 and faultLevel = 0.
- R5: An entry with bit 0 clear ends the walk with faultLevel equal to its level (1 root, 2 middle, 3 leaf). On any fault, donePaddr, donePerm and doneHuge are 0.
- R6: reqAccess codes are 0 read, 1 write and 2 execute, each needing entry bit 1, 2 or 3 of the final entry. Code 3 is never permitted. A denied access faults at the level of the final entry.
- R7: A valid middle entry with bit 4 set ends the walk after two reads. The result is donePaddr = {entry[63:23], vaddr[22:0]} and doneHuge = 1, with the permission check of R6 applied.
- R8: Bit 4 set in a valid root or leaf entry is a fault at that level.
- R9: Bits 3:1 of a root or middle entry without bit 4 have no effect on the result.
- R10: reqReady is low from the cycle after acceptance until the done pulse. doneValid lasts one cycle, and reqReady returns high on the next cycle.
- R11: memReqValid and memReqAddr stay unchanged until memReqReady is sampled high. Each entry is requested once.
- R12: vaddr[63:43] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| reqValid | input | 1 | walk request |
| reqReady | output | 1 | walker idle, request accepted when both high |
| reqVaddr | input | 64 | virtual address to translate |
| reqAccess | input | 2 | access type code |
| rootBase | input | 64 | root table base, sampled at acceptance |
| memReqValid | output | 1 | entry read request |
| memReqReady | input | 1 | memory accepts the read |
| memReqAddr | output | 64 | entry byte address |
| memRspValid | input | 1 | entry data valid |
| memRspData | input | 64 | entry data |
| doneValid | output | 1 | one-cycle walk completion |
| donePaddr | output | 64 | translated physical address |
| donePerm | output | 3 | execute, write, read bits of the final entry |
| doneHuge | output | 1 | translation is a huge page |
| faultLevel | output | 2 | 0 no fault, else failing level 1..3 |

## Verification
A read request appears one cycle after acceptance and is held until a handshake. Each response is consumed on the edge it is sampled. The done pulse follows the edge that consumed the final response. The next request for a non-terminal entry is issued the cycle after that response. The bench samples on falling edges: it checks reqReady low one cycle after the request, polls for doneValid, and checks all results in that same cycle. It then checks the pulse is gone and reqReady is back one cycle later. The memory model applies random backpressure and random response latency. It logs every address handshake, so both the order of reads and their number are compared against the model walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef struct packed {
    logic start;    // capture request, load root base
    logic advance;  // entry is a pointer, descend one level
    logic finish;   // entry ends the walk, latch result
  } walkCtl_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  output logic     memReqValid,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     rspTerminal,
  output logic     doneValid,
  output walkCtl_t ctl
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      S_IDLE:  if (reqValid) begin ctl.start = 1'b1; stateNext = S_ISSUE; end
      S_ISSUE: if (memReqReady) stateNext = S_WAIT;
      S_WAIT:  if (memRspValid) begin
                 if (rspTerminal) begin ctl.finish = 1'b1; stateNext = S_DONE; end
                 else begin ctl.advance = 1'b1; stateNext = S_ISSUE; end
               end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign doneValid   = (state == S_DONE);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  assert_no_req_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 13,
  parameter int LVL_N  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [ADDR_W-1:0] rootBase,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspTerminal,
  output logic [ADDR_W-1:0] donePaddr,
  output logic [2:0]        donePerm,
  output logic              doneHuge,
  output logic [$clog2(LVL_N+1)-1:0] faultLevel
);
  localparam int LVL_W     = $clog2(LVL_N+1);
  localparam int PTE_SHIFT = 3;
  localparam int HUGE_LVL  = LVL_N - 2;
  localparam int HUGE_OFF  = OFF_W + IDX_W;

  logic [ADDR_W-1:0] vaReg, baseReg;
  logic [1:0]        accReg;
  logic [LVL_W-1:0]  lvlReg;
  logic [IDX_W-1:0]  idx;

  // index field for the current level
  always_comb begin
    idx = '0;
    for (int i = 0; i < LVL_N; i++)
      if (lvlReg == LVL_W'(i)) idx = vaReg[OFF_W + IDX_W*(LVL_N-1-i) +: IDX_W];
  end
  assign memReqAddr = baseReg + (ADDR_W'(idx) << PTE_SHIFT);

  // entry decode
  logic eValid, eRd, eWr, eEx, eLarge, atLast, atHuge, isFinal, badLarge, permOk, isFault;
  assign eValid   = memRspData[0];
  assign eRd      = memRspData[1];
  assign eWr      = memRspData[2];
  assign eEx      = memRspData[3];
  assign eLarge   = memRspData[4];
  assign atLast   = (lvlReg == LVL_W'(LVL_N-1));
  assign atHuge   = (lvlReg == LVL_W'(HUGE_LVL)) && eLarge;
  assign isFinal  = atLast || atHuge;
  assign badLarge = eLarge && (lvlReg != LVL_W'(HUGE_LVL));

  always_comb begin
    unique case (accReg)
      2'd0:    permOk = eRd;
      2'd1:    permOk = eWr;
      2'd2:    permOk = eEx;
      default: permOk = 1'b0;
    endcase
  end

  assign isFault     = !eValid || badLarge || (isFinal && !permOk);
  assign rspTerminal = isFault || isFinal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg <= '0; baseReg <= '0; accReg <= '0; lvlReg <= '0;
      donePaddr <= '0; donePerm <= '0; doneHuge <= 1'b0; faultLevel <= '0;
    end else begin
      if (ctl.start) begin
        vaReg   <= reqVaddr;
        accReg  <= reqAccess;
        baseReg <= rootBase;
        lvlReg  <= '0;
      end
      if (ctl.advance) begin
        baseReg <= {memRspData[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        lvlReg  <= lvlReg + 1'b1;
      end
      if (ctl.finish) begin
        if (isFault) begin
          faultLevel <= lvlReg + 1'b1;
          donePaddr  <= '0;
          donePerm   <= '0;
          doneHuge   <= 1'b0;
        end else begin
          faultLevel <= '0;
          donePaddr  <= atHuge ? {memRspData[ADDR_W-1:HUGE_OFF], vaReg[HUGE_OFF-1:0]}
                               : {memRspData[ADDR_W-1:OFF_W], vaReg[OFF_W-1:0]};
          donePerm   <= {eEx, eWr, eRd};
          doneHuge   <= atHuge;
        end
      end
    end
  end

  assert_granted_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> (faultLevel != '0 || (accReg != 2'd3 && donePerm[accReg])));
  assert_huge_only_mid_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> (!doneHuge || lvlReg == LVL_W'(HUGE_LVL)));
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (lvlReg < LVL_W'(LVL_N-1)));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 13,
  parameter int LVL_N  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [ADDR_W-1:0] rootBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePaddr,
  output logic [2:0]        donePerm,
  output logic              doneHuge,
  output logic [$clog2(LVL_N+1)-1:0] faultLevel
);
  walkCtl_t ctl;
  logic     rspTerminal;

  ptw_ctrl i_ctrl (
    .clk, .rstN, .reqValid, .reqReady, .memReqValid, .memReqReady,
    .memRspValid, .rspTerminal, .doneValid, .ctl
  );

  ptw_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_N(LVL_N)) i_dp (
    .clk, .rstN, .ctl, .reqVaddr, .reqAccess, .rootBase, .memReqAddr,
    .memRspData, .rspTerminal, .donePaddr, .donePerm, .doneHuge, .faultLevel
  );

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqReady, memReqValid, memReqReady = 0, memRspValid = 0;
  logic doneValid, doneHuge;
  logic [63:0] reqVaddr = 0, rootBase = 0, memReqAddr, memRspData = 0, donePaddr;
  logic [1:0] reqAccess = 0, faultLevel;
  logic [2:0] donePerm;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (.*);

  int nTests = 0, nFail = 0;
  logic [63:0] sA [3], sD [3];
  logic [63:0] reqLog [8];
  int nReq = 0, delay = 0;
  logic pend = 0, holdOff = 0;
  logic [63:0] pendAddr = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lookup(input logic [63:0] a);
    for (int i = 0; i < 3; i++) if (sA[i] == a) return sD[i];
    return 64'd0;
  endfunction

  // memory model: log handshakes at the edge, answer on falling edges
  always @(posedge clk) begin
    if (memReqValid && memReqReady) begin
      if (nReq < 8) reqLog[nReq] = memReqAddr;
      nReq++;
      pendAddr = memReqAddr;
      pend = 1;
      delay = $urandom % 3;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 0;
      if (pend) begin
        if (delay == 0) begin
          memRspValid = 1; memRspData = lookup(pendAddr); pend = 0;
        end else delay--;
      end
      memReqReady = holdOff ? 1'b0 : 1'($urandom % 2);
    end
  end

  // independent reference walk
  task automatic modelWalk(input logic [63:0] va, input logic [1:0] acc, input logic [63:0] base,
                           output int fl, output logic [63:0] pa, output logic [2:0] perm,
                           output bit huge, output int nR, output logic [63:0] eA [3]);
    logic [63:0] b = base, d;
    fl = 0; pa = 0; perm = 0; huge = 0; nR = 0;
    for (int l = 0; l < 3; l++) begin
      logic [9:0] ix = va[13 + 10*(2-l) +: 10];
      bit lg, fin, ok;
      eA[l] = b + {ix, 3'b000};
      nR++;
      d = lookup(eA[l]);
      if (!d[0]) begin fl = l + 1; return; end
      lg = d[4];
      if (lg && l != 1) begin fl = l + 1; return; end
      fin = (l == 2) || lg;
      if (fin) begin
        ok = (acc == 0) ? d[1] : (acc == 1) ? d[2] : (acc == 2) ? d[3] : 1'b0;
        if (!ok) begin fl = l + 1; return; end
        pa = lg ? {d[63:23], va[22:0]} : {d[63:13], va[12:0]};
        perm = d[3:1]; huge = lg;
        return;
      end
      b = {d[63:13], 13'd0};
    end
  endtask

  // scenario: 0 normal, 1 root invalid, 2 mid invalid, 3 leaf invalid,
  // 4 huge, 5 root large, 6 leaf large
  task automatic buildTables(input int sc, input logic [63:0] va, input logic [63:0] base,
                             input logic [2:0] leafPerm, input logic [2:0] upPerm);
    logic [63:0] f1 = {$urandom, $urandom} & ~64'h1FFF;
    logic [63:0] f2 = {$urandom, $urandom} & ~64'h1FFF;
    logic [63:0] f3 = {$urandom, $urandom} & ~64'h1FFF;
    sA[0] = base + {va[42:33], 3'b000};
    sD[0] = f1 | {upPerm, 1'b1};
    sA[1] = f1 + {va[32:23], 3'b000};
    sD[1] = f2 | {upPerm, 1'b1};
    sA[2] = f2 + {va[22:13], 3'b000};
    sD[2] = f3 | {leafPerm, 1'b1};
    case (sc)
      1: sD[0][0] = 1'b0;
      2: sD[1][0] = 1'b0;
      3: sD[2][0] = 1'b0;
      4: sD[1] = (f2 | 64'h10) | {leafPerm, 1'b1};
      5: sD[0][4] = 1'b1;
      6: sD[2][4] = 1'b1;
      default: ;
    endcase
  endtask

  task automatic runWalk(input string tag, input logic [63:0] va, input logic [1:0] acc,
                         input logic [63:0] base);
    int fl, nR;
    logic [63:0] pa;
    logic [2:0] perm;
    bit huge;
    logic [63:0] eA [3];
    modelWalk(va, acc, base, fl, pa, perm, huge, nR, eA);
    @(negedge clk);
    check(reqReady === 1'b1, "R10 idle before request", 64'(reqReady), 64'd1);
    nReq = 0;
    reqVaddr = va; reqAccess = acc; rootBase = base; reqValid = 1;
    @(negedge clk);
    reqValid = 0; reqVaddr = ~va; rootBase = ~base;
    check(reqReady === 1'b0, "R10 busy after accept", 64'(reqReady), 64'd0);
    while (doneValid !== 1'b1) @(negedge clk);
    check(faultLevel == 2'(fl), {tag, " faultLevel"}, 64'(faultLevel), 64'(fl));
    check(donePaddr == pa, {tag, " paddr"}, donePaddr, pa);
    check(donePerm == perm && doneHuge == huge, {tag, " perm/huge"},
          {60'd0, doneHuge, donePerm}, {60'd0, huge, perm});
    check(nReq == nR, "R11 read count", 64'(nReq), 64'(nR));
    for (int i = 0; i < nR && i < nReq; i++)
      check(reqLog[i] == eA[i], "R2 R3 entry address order", reqLog[i], eA[i]);
    @(negedge clk);
    check(doneValid === 1'b0 && reqReady === 1'b1, "R10 single-cycle done",
          {62'd0, doneValid, reqReady}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [63:0] va, base;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(reqReady === 1 && doneValid === 0 && memReqValid === 0, "R1 reset state",
          {61'd0, reqReady, doneValid, memReqValid}, 64'd4);
    rstN = 1;

    base = 64'h0000_0040_0000_0000;
    va   = 64'h0000_0123_4567_89AB;
    buildTables(0, va, base, 3'b001, 3'b000);
    runWalk("R4 read leaf", va, 2'd0, base);
    buildTables(0, va, base, 3'b101, 3'b000);
    runWalk("R6 write denied", va, 2'd1, base);
    buildTables(0, va, base, 3'b111, 3'b000);
    runWalk("R6 code3 never allowed", va, 2'd3, base);
    buildTables(0, va, base, 3'b100, 3'b111);
    runWalk("R9 upper perm ignored exec", va, 2'd2, base);
    buildTables(4, va, base, 3'b011, 3'b000);
    runWalk("R7 huge page write", va, 2'd1, base);
    buildTables(4, va, base, 3'b001, 3'b000);
    runWalk("R7 huge page exec denied", va, 2'd2, base);
    buildTables(1, va, base, 3'b111, 3'b000);
    runWalk("R5 root invalid", va, 2'd0, base);
    buildTables(3, va, base, 3'b111, 3'b000);
    runWalk("R5 leaf invalid", va, 2'd0, base);
    buildTables(5, va, base, 3'b111, 3'b111);
    runWalk("R8 root large", va, 2'd0, base);
    buildTables(6, va, base, 3'b111, 3'b000);
    runWalk("R8 leaf large", va, 2'd0, base);
    buildTables(0, va, base, 3'b111, 3'b000);
    runWalk("R12 top bits ones", va | 64'hFFFF_F800_0000_0000, 2'd0, base);

    // R11: backpressure keeps the request stable
    holdOff = 1;
    @(negedge clk);
    nReq = 0;
    reqVaddr = va; reqAccess = 0; rootBase = base; reqValid = 1;
    @(negedge clk); reqValid = 0;
    repeat (4) @(negedge clk);
    check(memReqValid === 1'b1 && memReqAddr == sA[0] && nReq == 0, "R11 held under backpressure",
          memReqAddr, sA[0]);
    holdOff = 0;
    while (doneValid !== 1'b1) @(negedge clk);
    check(donePaddr == {sD[2][63:13], va[12:0]}, "R11 walk completes after release",
          donePaddr, {sD[2][63:13], va[12:0]});

    for (int n = 0; n < 150; n++) begin
      int sc = $urandom % 7;
      va   = {$urandom, $urandom};
      base = {$urandom, $urandom} & ~64'h1FFF;
      buildTables(sc, va, base, 3'($urandom), 3'($urandom));
      runWalk("R4 R5 R7 R8 random", va, 2'($urandom), base);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule